// File: doc/BRIEF.md
# USB device interrupt status logic

This block holds the interrupt status flags of a USB device-mode controller and the timed detectors that watch the bus. It takes the sampled D+/D- pair and single-cycle event pulses from the protocol engine. From these it keeps sticky flags for bus reset, idle, resume, start-of-frame, token completion and STALL sent. Software clears a flag by writing a one to its bit. A write of zero leaves the flag alone. The error bit is not stored: it is a live view of the masked error sources.

Each line-state detector is a cycle counter sized from the clock frequency parameter. The counter restarts whenever the line leaves the condition it watches, and it fires once for each unbroken stretch of that condition. When software clears the token-done flag, the block sends a one-cycle pop strobe to the transfer status FIFO. If that FIFO still holds entries, the flag sets again. An interrupt output combines the flags with an 8-bit enable vector.

Top module: `usb_dev_irq_status`

## Requirements
- R1: `status_o` is 16 bits with this layout: bit 0 bus reset, bit 1 error, bit 2 start-of-frame, bit 3 token done, bit 4 idle, bit 5 resume, bit 7 STALL. Bits 15..8 and bit 6 always read 0. After reset every flag is 0.
- R2: When `wr_i` is high, each bit of `wdata_i[7:0]` that is 1 clears the matching flag at the clock edge. Bits that are 0 have no effect.
- R3: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: The resume flag sets on the RESUME_CYC-th consecutive cycle of K state. RESUME_CYC = CLK_KHZ*25/10000. `line_i` is {D+, D-}. At full speed (`low_speed_i`=0) K is 2'b01. At low speed K is 2'b10.
- R5: The idle flag sets on the IDLE_CYC-th consecutive cycle of J state. IDLE_CYC = CLK_KHZ*3. J is 2'b10 at full speed and 2'b01 at low speed.
- R6: The bus-reset flag sets on the URST_CYC-th consecutive cycle of SE0 (2'b00). URST_CYC = CLK_KHZ*25/10000. Clearing the flag while SE0 continues does not set it again; only a new SE0 stretch can.
- R7: A pulse on `sof_i` sets bit 2, and a pulse on `stall_i` sets bit 7. Each flag is visible after the clock edge that samples the pulse.
- R8: A write with `wdata_i[3]`=1 while the token-done flag is 1 makes `stat_pop_o` high for exactly the next cycle. If `stat_nonempty_i` is 1 during that cycle, the token-done flag sets again at the next edge. A pulse on `trn_done_i` also sets it.
- R9: Bit 1 equals the OR of (`err_src_i` & `err_en_i`) in the same cycle. Writes have no effect on it.
- R10: `irq_o` is the OR of (`status_o[7:0]` & `irq_en_i`).
- R11: If the line leaves the watched state for even one cycle, that detector's count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Sampled bus state {D+, D-} |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| trn_done_i | input | 1 | Token processing complete pulse |
| sof_i | input | 1 | Start-of-frame received pulse |
| stall_i | input | 1 | STALL handshake sent pulse |
| stat_nonempty_i | input | 1 | Transfer status FIFO holds entries |
| err_src_i | input | 8 | Error source bits |
| err_en_i | input | 8 | Per-source error mask |
| wr_i | input | 1 | Status write strobe |
| wdata_i | input | 16 | Write data, 1 clears a flag |
| irq_en_i | input | 8 | Interrupt enable per status bit |
| status_o | output | 16 | Status register view |
| irq_o | output | 1 | Interrupt request |
| stat_pop_o | output | 1 | One-cycle status FIFO advance |

## Verification
The detectors are tested with K runs at both speed polarities, J runs and SE0 runs. Runs that stop one cycle short of the threshold tell an exact threshold apart from an off-by-one one. Runs broken by a single foreign cycle show that each counter restarts. Clearing the reset flag during SE0, and again after a fresh SE0 stretch, separates firing once per stretch from firing on a level. The sticky flags are tested with zero writes, with clears that land in the same cycle as a set, and with token-done clears made while the FIFO is empty and while it is not; these cases separate correct write-one-to-clear behaviour, set priority and pop-then-refill from their faulty variants. The error and interrupt masks are each tried with overlapping and disjoint patterns.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned BIT_URST  = 0;
  localparam int unsigned BIT_ERR   = 1;
  localparam int unsigned BIT_SOF   = 2;
  localparam int unsigned BIT_TRN   = 3;
  localparam int unsigned BIT_IDLE  = 4;
  localparam int unsigned BIT_RES   = 5;
  localparam int unsigned BIT_STALL = 7;
  localparam int unsigned NFLAG     = 8;
  // bits held in registers (error and bit 6 are not)
  localparam logic [NFLAG-1:0] STICKY_MASK = 8'b1011_1101;

  typedef enum logic [1:0] {
    LN_SE0   = 2'b00,
    LN_DIFF0 = 2'b01,
    LN_DIFF1 = 2'b10,
    LN_SE1   = 2'b11
  } line_e;

  typedef enum int unsigned {
    DET_RES  = 0,
    DET_IDLE = 1,
    DET_URST = 2
  } det_e;
endpackage

// File: rtl/usb_line_timer.sv
module usb_line_timer #(
  parameter int unsigned THRESH = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
  localparam logic [CW-1:0] SAT  = CW'(THRESH);

  logic [CW-1:0] cnt_q;

  // one pulse per unbroken run
  assign hit_o = match_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!match_i)    cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_line_detect.sv
module usb_line_detect #(
  parameter int unsigned RESUME_CYC = 120,
  parameter int unsigned IDLE_CYC   = 144000,
  parameter int unsigned URST_CYC   = 120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       low_speed_i,
  output logic [2:0] hit_o
);
  import usb_irq_pkg::*;

  localparam int unsigned TH [3] = '{RESUME_CYC, IDLE_CYC, URST_CYC};

  logic is_j, is_k, is_se0;
  logic [2:0] match;

  always_comb begin
    is_se0 = (line_i == LN_SE0);
    if (low_speed_i) begin
      is_j = (line_i == LN_DIFF0);
      is_k = (line_i == LN_DIFF1);
    end else begin
      is_j = (line_i == LN_DIFF1);
      is_k = (line_i == LN_DIFF0);
    end
    match[DET_RES]  = is_k;
    match[DET_IDLE] = is_j;
    match[DET_URST] = is_se0;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tmr
    usb_line_timer #(.THRESH(TH[g])) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .match_i(match[g]),
      .hit_o  (hit_o[g])
    );
  end
endmodule

// File: rtl/usb_w1c_bank.sv
module usb_w1c_bank #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (IMPL[b]) begin : g_reg
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= 1'b0;
        else if (set_i[b])  q <= 1'b1;   // set beats clear
        else if (clr_i[b])  q <= 1'b0;
      end
      assign q_o[b] = q;
    end else begin : g_none
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status #(
  parameter int unsigned CLK_KHZ    = 48000,
  parameter int unsigned RESUME_CYC = CLK_KHZ * 25 / 10000,
  parameter int unsigned IDLE_CYC   = CLK_KHZ * 3,
  parameter int unsigned URST_CYC   = CLK_KHZ * 25 / 10000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  line_i,
  input  logic        low_speed_i,
  input  logic        trn_done_i,
  input  logic        sof_i,
  input  logic        stall_i,
  input  logic        stat_nonempty_i,
  input  logic [7:0]  err_src_i,
  input  logic [7:0]  err_en_i,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic [7:0]  irq_en_i,
  output logic [15:0] status_o,
  output logic        irq_o,
  output logic        stat_pop_o
);
  import usb_irq_pkg::*;

  logic [2:0]       hit;
  logic [NFLAG-1:0] set, clr, flags;
  logic [NFLAG-1:0] view;
  logic             pop_q;

  usb_line_detect #(
    .RESUME_CYC(RESUME_CYC),
    .IDLE_CYC  (IDLE_CYC),
    .URST_CYC  (URST_CYC)
  ) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .low_speed_i(low_speed_i),
    .hit_o      (hit)
  );

  always_comb begin
    set            = '0;
    set[BIT_URST]  = hit[DET_URST];
    set[BIT_IDLE]  = hit[DET_IDLE];
    set[BIT_RES]   = hit[DET_RES];
    set[BIT_SOF]   = sof_i;
    set[BIT_STALL] = stall_i;
    set[BIT_TRN]   = trn_done_i | (pop_q & stat_nonempty_i);
    clr            = wr_i ? wdata_i[NFLAG-1:0] : '0;
  end

  usb_w1c_bank #(.N(NFLAG), .IMPL(STICKY_MASK)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr),
    .q_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_q <= 1'b0;
    else         pop_q <= clr[BIT_TRN] & flags[BIT_TRN];
  end

  always_comb begin
    view          = flags;
    view[BIT_ERR] = |(err_src_i & err_en_i);
  end

  assign status_o   = {8'h00, view};
  assign irq_o      = |(view & irq_en_i);
  assign stat_pop_o = pop_q;
endmodule

// File: rtl/usb_dev_irq_status_chk.sv
module usb_dev_irq_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trn_done_i,
  input logic        sof_i,
  input logic        stall_i,
  input logic [7:0]  err_src_i,
  input logic [7:0]  err_en_i,
  input logic        wr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] status_o,
  input logic        stat_pop_o
);
  // R1
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15:8] == 8'h00) && !status_o[6]);

  // R9
  err_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] == |(err_src_i & err_en_i));

  // R7
  stall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> status_o[7]);

  // R3
  sof_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && wr_i && wdata_i[2]) |=> status_o[2]);

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !(wr_i && wdata_i[7])) |=> status_o[7]);

  // R8
  pop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pop_o |=> !stat_pop_o);

  // R8
  pop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_pop_o) |-> $past(wr_i && wdata_i[3] && status_o[3]));

  // R8
  trn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trn_done_i |=> status_o[3]);
endmodule

bind usb_dev_irq_status usb_dev_irq_status_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trn_done_i(trn_done_i),
  .sof_i     (sof_i),
  .stall_i   (stall_i),
  .err_src_i (err_src_i),
  .err_en_i  (err_en_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .status_o  (status_o),
  .stat_pop_o(stat_pop_o)
);

// File: tb/usb_dev_irq_status_bench.sv
module usb_dev_irq_status_bench;
  localparam int CLKP   = 10;
  localparam int KHZ    = 4000;
  localparam int RES_N  = 10;
  localparam int IDLE_N = 12000;
  localparam int URST_N = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  line = 2'b11;
  logic        ls = 0;
  logic        trn = 0, sof = 0, stall = 0, nonempty = 0;
  logic [7:0]  esrc = 0, een = 0, ien = 0;
  logic        wr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] status;
  logic        irq, pop;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  usb_dev_irq_status #(.CLK_KHZ(KHZ)) u_usb_dev_irq_status (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .low_speed_i(ls),
    .trn_done_i(trn), .sof_i(sof), .stall_i(stall),
    .stat_nonempty_i(nonempty), .err_src_i(esrc), .err_en_i(een),
    .wr_i(wr), .wdata_i(wdata), .irq_en_i(ien),
    .status_o(status), .irq_o(irq), .stat_pop_o(pop)
  );

  // reference model
  bit m_f [8];
  bit m_pop;
  int run_k, run_j, run_0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_f[i]) m_f[i] = 0;
      m_pop = 0; run_k = 0; run_j = 0; run_0 = 0;
    end else begin
      bit k, j, s0, set [8], old_trn, old_pop;
      k  = ls ? (line == 2'b10) : (line == 2'b01);
      j  = ls ? (line == 2'b01) : (line == 2'b10);
      s0 = (line == 2'b00);
      run_k = k  ? run_k + 1 : 0;
      run_j = j  ? run_j + 1 : 0;
      run_0 = s0 ? run_0 + 1 : 0;
      foreach (set[i]) set[i] = 0;
      set[5] = (run_k == RES_N);
      set[4] = (run_j == IDLE_N);
      set[0] = (run_0 == URST_N);
      set[2] = sof;
      set[7] = stall;
      set[3] = trn || (m_pop && nonempty);
      old_trn = m_f[3];
      old_pop = m_pop;
      for (int b = 0; b < 8; b++) begin
        if (b == 1 || b == 6) continue;
        if (set[b]) m_f[b] = 1;
        else if (wr && wdata[b]) m_f[b] = 0;
      end
      m_pop = wr && wdata[3] && old_trn;
      if (old_pop) ; // pop consumed
    end
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] s = 0;
    s[0] = m_f[0]; s[2] = m_f[2]; s[3] = m_f[3]; s[4] = m_f[4];
    s[5] = m_f[5]; s[7] = m_f[7];
    s[1] = |(esrc & een);
    return s;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(posedge clk) begin
    #(CLKP/4);
    if (rst_n && !done) begin
      logic [15:0] e;
      e = exp_status();
      check("R1 upper", {status[15:8], 7'b0, status[6]}, 16'h0);
      check("R6 urst",  status[0], e[0]);
      check("R9 err",   status[1], e[1]);
      check("R7 sof",   status[2], e[2]);
      check("R8 trn",   status[3], e[3]);
      check("R5 idle",  status[4], e[4]);
      check("R4 resume", status[5], e[5]);
      check("R7 stall", status[7], e[7]);
      check("R10 irq",  irq, |(e[7:0] & ien));
      check("R8 pop",   pop, m_pop);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    @(posedge clk); #(CLKP/4);
  endtask

  task automatic wclr(logic [15:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic hold(logic [1:0] l, int n);
    @(negedge clk); line = l;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    cyc(2);
    rst_n = 1;
    settle();
    check("R1 reset status", status, 16'h0);
    check("R1 reset irq", irq, 0);

    // R7 stall, R2 zero write
    @(negedge clk); stall = 1; @(negedge clk); stall = 0;
    settle(); check("R7 stall set", status[7], 1);
    wclr(16'h0000); settle(); check("R2 zero write", status[7], 1);
    wclr(16'hFF7F); settle(); check("R2 other bits", status[7], 1);
    wclr(16'h0080); settle(); check("R2 clear", status[7], 0);

    // R3 set vs clear
    @(negedge clk); sof = 1; wr = 1; wdata = 16'h0004;
    @(negedge clk); sof = 0; wr = 0; wdata = 0;
    settle(); check("R3 set wins", status[2], 1);
    wclr(16'h0004);

    // R8 pop and refill
    @(negedge clk); trn = 1; @(negedge clk); trn = 0;
    nonempty = 1;
    wclr(16'h0008);
    settle(); check("R8 refilled", status[3], 1);
    nonempty = 0;
    wclr(16'h0008);
    settle(); check("R8 empty clear", status[3], 0);
    wclr(16'h0008); // flag already 0: no pop
    cyc(2);

    // R9 error view, R10 irq
    @(negedge clk); esrc = 8'h0F; een = 8'hF0; settle(); check("R9 disjoint", status[1], 0);
    @(negedge clk); een = 8'h18; settle(); check("R9 overlap", status[1], 1);
    wclr(16'h0002); settle(); check("R9 write ignored", status[1], 1);
    @(negedge clk); ien = 8'h02; settle(); check("R10 err irq", irq, 1);
    @(negedge clk); ien = 8'hFD; settle(); check("R10 masked", irq, 0);
    @(negedge clk); esrc = 0; een = 0;

    // R4 full speed K with break (R11)
    hold(2'b01, RES_N - 1);
    hold(2'b10, 1);
    hold(2'b01, RES_N - 1);
    settle(); check("R11 resume restart", status[5], 0);
    cyc(1); settle(); check("R4 resume fs", status[5], 1);
    hold(2'b11, 2); wclr(16'h0020);
    // low speed K
    @(negedge clk); ls = 1;
    hold(2'b10, RES_N);
    settle(); check("R4 resume ls", status[5], 1);
    hold(2'b11, 2); wclr(16'h0020);
    @(negedge clk); ls = 0;

    // R6 reset, one shot per run
    hold(2'b00, URST_N);
    settle(); check("R6 reset set", status[0], 1);
    wclr(16'h0001);
    cyc(URST_N + 3);
    settle(); check("R6 no reassert", status[0], 0);
    hold(2'b11, 2);
    hold(2'b00, URST_N - 1);
    settle(); check("R6 short run", status[0], 0);
    cyc(1); settle(); check("R6 new run", status[0], 1);
    hold(2'b11, 2); wclr(16'h0001);

    // R5 idle with restart (R11)
    hold(2'b10, IDLE_N - 1);
    hold(2'b00, 1);
    hold(2'b10, IDLE_N - 1);
    settle(); check("R11 idle restart", status[4], 0);
    cyc(1); settle(); check("R5 idle", status[4], 1);
    @(negedge clk); ien = 8'h10; settle(); check("R10 idle irq", irq, 1);
    hold(2'b11, 2);
    wclr(16'h00FF);
    settle(); check("R2 all clear", status & 16'h00BD, 16'h0);
    cyc(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule